// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic half of a simple integer datapath. Each cycle it takes an operation code and two operands and produces a result, a write-enable for that result and a four-bit condition flag set. The operations are add, add-with-carry, subtract, subtract-with-carry, reverse subtract, move, move-complement, compare and compare-negative. The second operand is either a register value or a zero-extended immediate.

The result and write-enable are combinational. The flags live in a register that updates on the next rising clock edge. A set-flags input lets an ordinary operation update the flags. Compares always update them and never write a result. The stored carry feeds the carry-consuming operations, so two ALU cycles can chain a double-width add or subtract.

Top module: `flag_alu`

## Requirements
- R1: When the flags update, N (flags_o bit 3) takes the most significant bit of the result.
- R2: When the flags update, Z (flags_o bit 2) is 1 exactly when every bit of the result is 0.
- R3: When an arithmetic operation updates the flags, C (flags_o bit 1) is the unsigned carry-out for additions. For subtract-type operations it is "no borrow": 1 when the minuend is greater than or equal to the subtrahend plus any borrow-in.
- R4: When an arithmetic operation updates the flags, V (flags_o bit 0) is 1 exactly when the true signed result falls outside the two's-complement range of WIDTH bits.
- R5: With set_flags_i low and an operation other than a compare, flags_o keeps its previous value.
- R6: Compare (op 7) evaluates a - b and compare-negative (op 8) evaluates a + b. Both update all four flags whatever set_flags_i is, and both hold wr_en_o low.
- R7: The arithmetic operations raise wr_en_o and give results modulo 2^WIDTH: add (op 0) a + b, add-with-carry (op 1) a + b + C, subtract (op 2) a - b, subtract-with-carry (op 3) a - b - (1 - C), reverse subtract (op 4) b - a. C is the stored flag.
- R8: Move (op 5) outputs b and move-complement (op 6) outputs the bitwise inverse of b, with wr_en_o high. With set_flags_i high they update N and Z, and C and V keep their values.
- R9: With use_imm_i high, operand b is imm_i zero-extended to WIDTH bits, and opb_i has no effect.
- R10: Driving rst_n low clears flags_o to 0000 at once, without waiting for a clock edge.
- R11: Op codes 9 to 15 hold wr_en_o low and leave the flags unchanged, even with set_flags_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Lets a non-compare operation update the flags |
| use_imm_i | input | 1 | Selects the immediate as operand b |
| opa_i | input | WIDTH | Operand a |
| opb_i | input | WIDTH | Register operand b |
| imm_i | input | IMM_W | Immediate, zero-extended when selected |
| result_o | output | WIDTH | Operation result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Stored flags {N, Z, C, V} |

## Verification
The only state in the block is the flag register. A wrong flag shows up in flags_o one edge after the updating operation. A wrong stored carry also shows up in the combinational result of the next add-with-carry or subtract-with-carry, within the same cycle that operation is applied. For this reason the sweep sets C to a known value immediately before each vector, and it checks both the result and every flag bit after each edge. A flag that changes when it should hold is visible on the edge that follows the non-updating operation.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_RSB = 4'd4;
  localparam logic [3:0] OP_MOV = 4'd5;
  localparam logic [3:0] OP_MVN = 4'd6;
  localparam logic [3:0] OP_CMP = 4'd7;
  localparam logic [3:0] OP_CMN = 4'd8;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic     valid;
    logic     arith;
    logic     swap;
    logic     inv_y;
    cin_sel_e cin_sel;
    logic     mov_inv;
    logic     write;
    logic     force_flags;
  } alu_ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/falu_decode.sv
module falu_decode
  import flag_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{valid: 1'b1, arith: 1'b0, swap: 1'b0, inv_y: 1'b0,
               cin_sel: CIN_ZERO, mov_inv: 1'b0, write: 1'b0,
               force_flags: 1'b0};
    case (op_i)
      OP_ADD: begin ctrl_o.arith = 1'b1; ctrl_o.write = 1'b1; end
      OP_ADC: begin
        ctrl_o.arith = 1'b1; ctrl_o.cin_sel = CIN_FLAG; ctrl_o.write = 1'b1;
      end
      OP_SUB: begin
        ctrl_o.arith = 1'b1; ctrl_o.inv_y = 1'b1;
        ctrl_o.cin_sel = CIN_ONE; ctrl_o.write = 1'b1;
      end
      OP_SBC: begin
        ctrl_o.arith = 1'b1; ctrl_o.inv_y = 1'b1;
        ctrl_o.cin_sel = CIN_FLAG; ctrl_o.write = 1'b1;
      end
      OP_RSB: begin
        ctrl_o.arith = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.inv_y = 1'b1;
        ctrl_o.cin_sel = CIN_ONE; ctrl_o.write = 1'b1;
      end
      OP_MOV: ctrl_o.write = 1'b1;
      OP_MVN: begin ctrl_o.mov_inv = 1'b1; ctrl_o.write = 1'b1; end
      OP_CMP: begin
        ctrl_o.arith = 1'b1; ctrl_o.inv_y = 1'b1;
        ctrl_o.cin_sel = CIN_ONE; ctrl_o.force_flags = 1'b1;
      end
      OP_CMN: begin ctrl_o.arith = 1'b1; ctrl_o.force_flags = 1'b1; end
      default: ctrl_o.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/falu_opnd_sel.sv
module falu_opnd_sel #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 12
) (
  input  logic             use_imm_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0] opnd_o
);

  localparam int PAD_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] imm_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm_i};
    end else begin : g_full
      assign imm_ext = imm_i[WIDTH-1:0];
    end
  endgenerate

  assign opnd_o = use_imm_i ? imm_ext : reg_i;

endmodule

// File: rtl/falu_addsub.sv
module falu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;

  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic             set_flags_i,
  input  logic             use_imm_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  alu_flags_t       flags_q, flags_d;
  logic [WIDTH-1:0] op2, x, y_raw, y, sum, move_val;
  logic             cin, cout, ovf, flags_en;

  falu_decode i_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  falu_opnd_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) i_opnd_sel (
    .use_imm_i (use_imm_i),
    .reg_i     (opb_i),
    .imm_i     (imm_i),
    .opnd_o    (op2)
  );

  always_comb begin
    x     = ctrl.swap ? op2 : opa_i;
    y_raw = ctrl.swap ? opa_i : op2;
    y     = ctrl.inv_y ? ~y_raw : y_raw;
    case (ctrl.cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = flags_q.c;
      default:  cin = 1'b0;
    endcase
  end

  falu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .x_i    (x),
    .y_i    (y),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  assign move_val = ctrl.mov_inv ? ~op2 : op2;
  assign result_o = ctrl.arith ? sum : move_val;
  assign wr_en_o  = ctrl.valid & ctrl.write;

  // Flag next-state
  assign flags_en = ctrl.valid & (ctrl.force_flags | set_flags_i);

  always_comb begin
    flags_d   = flags_q;
    flags_d.n = result_o[MSB];
    flags_d.z = (result_o == '0);
    if (ctrl.arith) begin
      flags_d.c = cout;
      flags_d.v = ovf;
    end
  end

  // Flag register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/falu_chk.sv
module falu_chk
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic [3:0]       flags_o
);

  logic is_cmp, is_move, op_known, upd;

  assign is_cmp   = (op_i == OP_CMP) || (op_i == OP_CMN);
  assign is_move  = (op_i == OP_MOV) || (op_i == OP_MVN);
  assign op_known = (op_i <= OP_CMN);
  assign upd      = is_cmp || (set_flags_i && op_known);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |-> !wr_en_o); // R6

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known |-> !wr_en_o); // R11

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_o)); // R5

  AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags_o[3] == $past(result_o[WIDTH-1])); // R1

  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags_o[2] == ($past(result_o) == '0)); // R2

  AST_MOVE_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (is_move && set_flags_i) |=> flags_o[1:0] == $past(flags_o[1:0])); // R8

endmodule

bind flag_alu falu_chk #(.WIDTH(WIDTH)) i_falu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .flags_o     (flags_o)
);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;

  localparam int W     = 4;
  localparam int IW    = 3;
  localparam int MOD   = 1 << W;
  localparam int HALF  = 1 << (W - 1);
  localparam real TCLK = 8.0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    op_i;
  logic          set_flags_i, use_imm_i;
  logic [W-1:0]  opa_i, opb_i;
  logic [IW-1:0] imm_i;
  logic [W-1:0]  result_o;
  logic          wr_en_o;
  logic [3:0]    flags_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(TCLK / 2) clk = ~clk;

  flag_alu #(.WIDTH(W), .IMM_W(IW)) i_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
    .use_imm_i(use_imm_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= HALF) ? v - MOD : v;
  endfunction

  // Apply inputs at the falling edge, settle 1 ns.
  task automatic apply(input int op, input int sf, input int ui,
                       input int a, input int b, input int imm);
    @(negedge clk);
    op_i        = op[3:0];
    set_flags_i = sf[0];
    use_imm_i   = ui[0];
    opa_i       = a[W-1:0];
    opb_i       = b[W-1:0];
    imm_i       = imm[IW-1:0];
    #1;
  endtask

  // Put C to a known value: CMP 0,0 -> 0110, CMN 0,0 -> 0100.
  task automatic preset_c(input int c);
    apply(c ? 7 : 8, 0, 0, 0, 0, 0);
  endtask

  task automatic run_sweep();
    for (int op = 0; op <= 8; op++)
      for (int sf = 0; sf <= 1; sf++)
        for (int c = 0; c <= 1; c++)
          for (int a = 0; a < MOD; a++)
            for (int b = 0; b < MOD; b++) begin
              int u, s, res, prev, nf, en, arith;
              string tg;
              preset_c(c);
              prev  = c ? 4'b0110 : 4'b0100;
              arith = 1;
              case (op)
                0: begin u = a + b;            s = sgn(a) + sgn(b);             end
                1: begin u = a + b + c;        s = sgn(a) + sgn(b) + c;         end
                2: begin u = a - b;            s = sgn(a) - sgn(b);             end
                3: begin u = a - b - (1 - c);  s = sgn(a) - sgn(b) - (1 - c);   end
                4: begin u = b - a;            s = sgn(b) - sgn(a);             end
                5: begin u = b;                s = 0; arith = 0;               end
                6: begin u = MOD - 1 - b;      s = 0; arith = 0;               end
                7: begin u = a - b;            s = sgn(a) - sgn(b);             end
                default: begin u = a + b;      s = sgn(a) + sgn(b);             end
              endcase
              res = (u + 2 * MOD) % MOD;
              apply(op, sf, 0, a, b, 0);
              tg = (op >= 7) ? "R6" : (op >= 5) ? "R8" : "R7";
              if (op < 7) chk(tg, "result", int'(result_o), res);
              chk(tg, "wr_en", int'(wr_en_o), (op < 7) ? 1 : 0);
              en = (op >= 7) || (sf == 1);
              nf = prev;
              if (en) begin
                nf = ((res >= HALF) ? 8 : 0) | ((res == 0) ? 4 : 0);
                if (arith) begin
                  if (op == 0 || op == 1 || op == 8) nf |= (u >= MOD) ? 2 : 0;
                  else                               nf |= (u >= 0) ? 2 : 0;
                  nf |= (s >= HALF || s < -HALF) ? 1 : 0;
                end else begin
                  nf |= prev & 3;
                end
              end
              @(posedge clk); #1;
              if (!en) chk("R5", "flags hold", int'(flags_o), nf);
              else begin
                chk("R1", "N", int'(flags_o[3]), (nf >> 3) & 1);
                chk("R2", "Z", int'(flags_o[2]), (nf >> 2) & 1);
                chk(arith ? "R3" : "R8", "C", int'(flags_o[1]), (nf >> 1) & 1);
                chk(arith ? "R4" : "R8", "V", int'(flags_o[0]), nf & 1);
              end
            end
  endtask

  initial begin
    rst_n = 1'b0; op_i = '0; set_flags_i = 1'b0; use_imm_i = 1'b0;
    opa_i = '0; opb_i = '0; imm_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R10", "flags after reset", int'(flags_o), 0);

    run_sweep();

    // Immediate operand: zero-extended, opb ignored
    for (int imm = 0; imm < (1 << IW); imm++)
      for (int a = 0; a < MOD; a++) begin
        apply(0, 0, 1, a, MOD - 1, imm);
        chk("R9", "add imm", int'(result_o), (a + imm) % MOD);
      end
    apply(5, 0, 1, 0, MOD - 1, (1 << IW) - 1);
    chk("R9", "mov imm zero-ext", int'(result_o), (1 << IW) - 1);

    // Undefined op codes
    for (int op = 9; op <= 15; op++) begin
      apply(7, 0, 0, 0, 1, 0);  // CMP 0,1 -> N=1 Z=0 C=0 V=0
      apply(op, 1, 0, 0, 0, 0);
      chk("R11", "wr_en undefined", int'(wr_en_o), 0);
      @(posedge clk); #1;
      chk("R11", "flags undefined", int'(flags_o), 4'b1000);
    end

    // Asynchronous reset between edges
    apply(7, 0, 0, 0, 1, 0);
    @(posedge clk); #1;
    chk("R10", "flags before async reset", int'(flags_o), 4'b1000);
    #1 rst_n = 1'b0; #0.5;
    chk("R10", "flags in async reset", int'(flags_o), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (R1 sweep not finished)");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule